// File: doc/BRIEF.md
# Floating-Point Register Rename Status Table

This block holds the architected floating-point register values together with a status table. For each register, the table names the reservation station that will produce the next value of that register. Blank means no pending writer, and blank is encoded as tag 0. The issue stage presents source register indices and reads back, for each source, one of two things. If the register has no pending writer, it gets the register value with tag 0. If the register has a pending writer, it gets that writer's tag with a zero value. When the issued instruction writes a destination, its station tag replaces whatever tag the destination held before. A younger writer therefore supersedes an older one without stalling.

Completed results arrive on a broadcast bus that carries a data word and the tag of the producing station. Each register compares its status against that tag. Only the register whose latest recorded writer matches captures the data and returns to blank. A result from a superseded producer leaves the register alone. Instructions issue in order, while results may come back in any order.

The source lookup is combinational, so a lookup sees the same cycle's broadcast. A source whose producer is broadcasting right now is handed the broadcast data as ready. A parameter can remove that bypass.

Top module: `fp_rename_table`

## Requirements
- R1: After reset, every register reads value 0 with tag 0.
- R2: A source lookup of a register with blank status returns that register's stored value and tag 0, in the same cycle.
- R3: A source lookup of a register with a pending writer returns that writer's tag and a value of 0.
- R4: An issue with iss_valid_i=1 and iss_dst_en_i=1 sets the status of register iss_dst_i to iss_tag_i from the next cycle on. This replaces any older pending tag. The tag must be nonzero.
- R5: A broadcast with bcast_valid_i=1 whose tag equals a register's nonzero status writes bcast_data_i into that register and sets its status to blank from the next cycle on.
- R6: A broadcast whose tag no longer matches a register's status leaves that register's value and status unchanged.
- R7: A lookup of a register whose pending writer broadcasts in the same cycle returns the broadcast data with tag 0.
- R8: When an issue targets a register in the same cycle that its current producer broadcasts, the register's status afterwards holds the new issue tag.
- R9: A source lookup made in the same cycle as an issue to the same register sees the state before that issue.
- R10: A broadcast with bcast_valid_i=0, or with tag 0, changes no register.
- R11: An issue with iss_valid_i=0 or iss_dst_en_i=0 changes no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | An instruction issues this cycle |
| iss_dst_en_i | input | 1 | The issuing instruction writes a destination register |
| iss_dst_i | input | IDX_W (2) | Destination register index |
| iss_tag_i | input | TAG_W (4) | Tag of the issuing station, nonzero |
| src_idx_i | input | NUM_SRC*IDX_W (4) | Source register indices; source s occupies bits [s*IDX_W +: IDX_W] |
| src_val_o | output | NUM_SRC*DATA_W (128) | Source values; source s occupies bits [s*DATA_W +: DATA_W] |
| src_tag_o | output | NUM_SRC*TAG_W (8) | Source producer tags, 0 meaning ready; source s occupies bits [s*TAG_W +: TAG_W] |
| bcast_valid_i | input | 1 | A result is on the broadcast bus |
| bcast_tag_i | input | TAG_W (4) | Tag of the station producing the result |
| bcast_data_i | input | DATA_W (64) | Result data |

## Verification
The bench goes after write-after-write ordering. Two writers are queued on one register and the older one broadcasts first. A table that compared destinations instead of the latest tag would let that stale result overwrite the register and clear it, so the younger consumer would never see its producer. It drives a lookup in the very cycle the producer broadcasts. A design without the bypass would hand out a tag that nobody will broadcast again, and the consumer would wait forever. It also issues over a register in the cycle its old producer completes, where a clear that won over the new tag would mark the register ready with the wrong value. Finally, it reads a source that is also the destination of the same issue. There a lookup taken after the update would chain the instruction to itself.

// File: rtl/rrst_pkg.sv
package rrst_pkg;

   // Outcome of one source lookup
   typedef enum logic [1:0] {
      SRC_READY   = 2'd0,
      SRC_BYPASS  = 2'd1,
      SRC_WAITING = 2'd2,
      SRC_NONE    = 2'd3
   } src_kind_e;

   // Tag value that marks a register as having no pending writer
   function automatic logic tag_is_blank(input logic [15:0] tag);
      return tag == 16'd0;
   endfunction

endpackage

// File: rtl/rrst_entry.sv
module rrst_entry #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 2,
   parameter int INDEX  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_wr,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic [DATA_W-1:0] value_o,
   output logic [TAG_W-1:0]  status_o
);

   logic [DATA_W-1:0] value_q;
   logic [TAG_W-1:0]  status_q;
   logic              iss_hit;
   logic              bc_match;

   assign iss_hit  = iss_wr && (iss_dst == IDX_W'(INDEX));
   assign bc_match = bc_valid && (status_q != '0) && (status_q == bc_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q  <= '0;
         status_q <= '0;
      end else begin
         if (bc_match)
            value_q <= bc_data;
         if (iss_hit)
            status_q <= iss_tag;
         else if (bc_match)
            status_q <= '0;
      end
   end

   assign value_o  = value_q;
   assign status_o = status_q;

   // R4
   iss_sets_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_hit |=> status_q == $past(iss_tag));

   // R5
   bcast_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_match && !iss_hit) |=> (status_q == '0) && (value_q == $past(bc_data)));

   // R8
   iss_over_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_match && iss_hit) |=> (value_q == $past(bc_data)) && (status_q != '0));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc_match && !iss_hit) |=> $stable(status_q) && $stable(value_q));

endmodule

// File: rtl/rrst_src_sel.sv
module rrst_src_sel
   import rrst_pkg::*;
#(
   parameter int NUM_REGS   = 4,
   parameter int DATA_W     = 64,
   parameter int TAG_W      = 4,
   parameter int IDX_W      = 2,
   parameter bit FWD_BYPASS = 1'b1
) (
   input  logic [IDX_W-1:0]  sel,
   input  logic [DATA_W-1:0] reg_val [NUM_REGS],
   input  logic [TAG_W-1:0]  reg_tag [NUM_REGS],
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic [DATA_W-1:0] val_o,
   output logic [TAG_W-1:0]  tag_o
);

   logic [DATA_W-1:0] pick_val;
   logic [TAG_W-1:0]  pick_tag;
   logic              in_range;
   logic              fwd_hit;
   src_kind_e         kind;

   always_comb begin
      pick_val = '0;
      pick_tag = '0;
      in_range = 1'b0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (sel == IDX_W'(r)) begin
            pick_val = reg_val[r];
            pick_tag = reg_tag[r];
            in_range = 1'b1;
         end
      end
   end

   generate
      if (FWD_BYPASS) begin : g_bypass
         assign fwd_hit = bc_valid && (pick_tag != '0) && (pick_tag == bc_tag);
      end else begin : g_no_bypass
         assign fwd_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!in_range)
         kind = SRC_NONE;
      else if (tag_is_blank(16'(pick_tag)))
         kind = SRC_READY;
      else if (fwd_hit)
         kind = SRC_BYPASS;
      else
         kind = SRC_WAITING;
   end

   always_comb begin
      unique case (kind)
         SRC_READY:   begin val_o = pick_val; tag_o = '0;       end
         SRC_BYPASS:  begin val_o = bc_data;  tag_o = '0;       end
         SRC_WAITING: begin val_o = '0;       tag_o = pick_tag; end
         default:     begin val_o = '0;       tag_o = '0;       end
      endcase
   end

endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table #(
   parameter int NUM_REGS   = 4,
   parameter int DATA_W     = 64,
   parameter int TAG_W      = 4,
   parameter int NUM_SRC    = 2,
   parameter bit FWD_BYPASS = 1'b1,
   localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      iss_valid_i,
   input  logic                      iss_dst_en_i,
   input  logic [IDX_W-1:0]          iss_dst_i,
   input  logic [TAG_W-1:0]          iss_tag_i,
   input  logic [NUM_SRC*IDX_W-1:0]  src_idx_i,
   output logic [NUM_SRC*DATA_W-1:0] src_val_o,
   output logic [NUM_SRC*TAG_W-1:0]  src_tag_o,
   input  logic                      bcast_valid_i,
   input  logic [TAG_W-1:0]          bcast_tag_i,
   input  logic [DATA_W-1:0]         bcast_data_i
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_regs
         $error("fp_rename_table: NUM_REGS out of range");
      end
      if (TAG_W < 1 || TAG_W > 16) begin : g_bad_tag
         $error("fp_rename_table: TAG_W must be 1..16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("fp_rename_table: DATA_W must be positive");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("fp_rename_table: NUM_SRC must be 1..4");
      end
   endgenerate

   logic              iss_wr;
   logic [DATA_W-1:0] reg_val [NUM_REGS];
   logic [TAG_W-1:0]  reg_tag [NUM_REGS];

   assign iss_wr = iss_valid_i && iss_dst_en_i;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
         rrst_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .IDX_W  (IDX_W),
            .INDEX  (r)
         ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_wr   (iss_wr),
            .iss_dst  (iss_dst_i),
            .iss_tag  (iss_tag_i),
            .bc_valid (bcast_valid_i),
            .bc_tag   (bcast_tag_i),
            .bc_data  (bcast_data_i),
            .value_o  (reg_val[r]),
            .status_o (reg_tag[r])
         );
      end

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         logic [IDX_W-1:0]  sel;
         logic [DATA_W-1:0] val;
         logic [TAG_W-1:0]  tag;
         logic [TAG_W-1:0]  seen_tag;

         assign sel = src_idx_i[s*IDX_W +: IDX_W];

         rrst_src_sel #(
            .NUM_REGS   (NUM_REGS),
            .DATA_W     (DATA_W),
            .TAG_W      (TAG_W),
            .IDX_W      (IDX_W),
            .FWD_BYPASS (FWD_BYPASS)
         ) u_sel (
            .sel      (sel),
            .reg_val  (reg_val),
            .reg_tag  (reg_tag),
            .bc_valid (bcast_valid_i),
            .bc_tag   (bcast_tag_i),
            .bc_data  (bcast_data_i),
            .val_o    (val),
            .tag_o    (tag)
         );

         assign src_val_o[s*DATA_W +: DATA_W] = val;
         assign src_tag_o[s*TAG_W +: TAG_W]   = tag;

         always_comb begin
            seen_tag = '0;
            for (int r = 0; r < NUM_REGS; r++)
               if (sel == IDX_W'(r)) seen_tag = reg_tag[r];
         end

         // R3
         pend_zero_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tag != '0) |-> (val == '0) && (tag == seen_tag));

         if (FWD_BYPASS) begin : g_fwd_chk
            // R7
            bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (bcast_valid_i && seen_tag != '0 && seen_tag == bcast_tag_i)
               |-> (tag == '0) && (val == bcast_data_i));
         end
      end
   endgenerate

   // R4
   iss_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_wr |-> (iss_tag_i != '0));

endmodule

// File: tb/fp_rename_table_test.sv
module fp_rename_table_test;

   localparam int NR = 4;
   localparam int DW = 64;
   localparam int TW = 4;
   localparam int NS = 2;
   localparam int IW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              iss_valid_i = 1'b0;
   logic              iss_dst_en_i = 1'b0;
   logic [IW-1:0]     iss_dst_i = '0;
   logic [TW-1:0]     iss_tag_i = '0;
   logic [NS*IW-1:0]  src_idx_i = '0;
   logic [NS*DW-1:0]  src_val_o;
   logic [NS*TW-1:0]  src_tag_o;
   logic              bcast_valid_i = 1'b0;
   logic [TW-1:0]     bcast_tag_i = '0;
   logic [DW-1:0]     bcast_data_i = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   fp_rename_table uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .iss_valid_i   (iss_valid_i),
      .iss_dst_en_i  (iss_dst_en_i),
      .iss_dst_i     (iss_dst_i),
      .iss_tag_i     (iss_tag_i),
      .src_idx_i     (src_idx_i),
      .src_val_o     (src_val_o),
      .src_tag_o     (src_tag_o),
      .bcast_valid_i (bcast_valid_i),
      .bcast_tag_i   (bcast_tag_i),
      .bcast_data_i  (bcast_data_i)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // look at source 0 = register a, source 1 = register b, after settling
   task automatic look(input int a, input int b);
      src_idx_i = {IW'(b), IW'(a)};
      #1;
   endtask

   task automatic chk_src(input string req, input int s, input logic [DW-1:0] val, input logic [TW-1:0] tag);
      check(req, src_val_o[s*DW +: DW], val);
      check(req, DW'(src_tag_o[s*TW +: TW]), DW'(tag));
   endtask

   task automatic idle();
      iss_valid_i = 1'b0; iss_dst_en_i = 1'b0; iss_dst_i = '0; iss_tag_i = '0;
      bcast_valid_i = 1'b0; bcast_tag_i = '0; bcast_data_i = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic set_issue(input int dst, input int tag);
      iss_valid_i = 1'b1; iss_dst_en_i = 1'b1; iss_dst_i = IW'(dst); iss_tag_i = TW'(tag);
   endtask

   task automatic set_bcast(input int tag, input logic [DW-1:0] data);
      bcast_valid_i = 1'b1; bcast_tag_i = TW'(tag); bcast_data_i = data;
   endtask

   task automatic t_reset();
      for (int r = 0; r < NR; r += 2) begin
         look(r, r + 1);
         chk_src("R1", 0, '0, '0);
         chk_src("R1", 1, '0, '0);
      end
   endtask

   task automatic t_pending_then_result();
      set_issue(1, 3);
      step();
      look(1, 0);
      chk_src("R3 R4", 0, '0, 4'd3);
      chk_src("R2", 1, '0, '0);
      set_bcast(3, 64'h1111_2222_3333_4444);
      step();
      look(1, 0);
      chk_src("R5", 0, 64'h1111_2222_3333_4444, '0);
   endtask

   task automatic t_waw();
      set_issue(2, 5);
      step();
      set_issue(2, 6);
      step();
      look(2, 1);
      chk_src("R4", 0, '0, 4'd6);
      set_bcast(5, 64'hDEAD_0000_0000_0005);
      step();
      look(2, 1);
      chk_src("R6", 0, '0, 4'd6);
      set_bcast(6, 64'hBEEF_0000_0000_0006);
      step();
      look(2, 1);
      chk_src("R5", 0, 64'hBEEF_0000_0000_0006, '0);
      chk_src("R2", 1, 64'h1111_2222_3333_4444, '0);
   endtask

   task automatic t_bypass();
      set_issue(0, 7);
      step();
      set_bcast(7, 64'h0707_0707_0707_0707);
      look(0, 2);
      chk_src("R7", 0, 64'h0707_0707_0707_0707, '0);
      chk_src("R2", 1, 64'hBEEF_0000_0000_0006, '0);
      step();
      look(0, 2);
      chk_src("R5", 0, 64'h0707_0707_0707_0707, '0);
   endtask

   task automatic t_issue_meets_bcast();
      set_issue(3, 8);
      step();
      set_issue(3, 9);
      set_bcast(8, 64'h0808_0808_0808_0808);
      look(3, 3);
      chk_src("R7", 0, 64'h0808_0808_0808_0808, '0);
      step();
      look(3, 0);
      chk_src("R8", 0, '0, 4'd9);
      set_bcast(9, 64'h0909_0909_0909_0909);
      step();
      look(3, 0);
      chk_src("R8", 0, 64'h0909_0909_0909_0909, '0);
   endtask

   task automatic t_self_source();
      set_issue(1, 10);
      look(1, 1);
      chk_src("R9", 0, 64'h1111_2222_3333_4444, '0);
      step();
      look(1, 0);
      chk_src("R9", 0, '0, 4'd10);
   endtask

   task automatic t_ignored();
      // broadcast not valid, though tag matches register 1
      bcast_valid_i = 1'b0; bcast_tag_i = TW'(10); bcast_data_i = 64'hAAAA;
      look(1, 0);
      chk_src("R10", 0, '0, 4'd10);
      step();
      look(1, 0);
      chk_src("R10", 0, '0, 4'd10);
      // tag 0 broadcast must not touch blank registers
      set_bcast(0, 64'h5555_5555_5555_5555);
      step();
      look(0, 2);
      chk_src("R10", 0, 64'h0707_0707_0707_0707, '0);
      chk_src("R10", 1, 64'hBEEF_0000_0000_0006, '0);
      // issue without valid, then without destination enable
      iss_valid_i = 1'b0; iss_dst_en_i = 1'b1; iss_dst_i = IW'(0); iss_tag_i = TW'(11);
      step();
      iss_valid_i = 1'b1; iss_dst_en_i = 1'b0; iss_dst_i = IW'(2); iss_tag_i = TW'(12);
      step();
      look(0, 2);
      chk_src("R11", 0, 64'h0707_0707_0707_0707, '0);
      chk_src("R11", 1, 64'hBEEF_0000_0000_0006, '0);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pending_then_result();
      t_waw();
      t_bypass();
      t_issue_meets_bcast();
      t_self_source();
      t_ignored();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule